// File: doc/BRIEF.md
# Smart Card Reset and Answer-to-Reset Sequencer

This block drives the contact lines of a contact smart card: supply enable, card clock, card reset and the I/O pull-down. A cold start powers the card, waits a short settling gap, then starts the card clock. The reset line is held low for a fixed number of card clock rising edges. During that hold the I/O line is released to the pulled-up receive state. After the reset line rises, the block opens a reception window, also measured in card clock rising edges, and waits for the falling start edge of the card's answer. A warm start from an established session pulses only the reset line. Supply and clock keep running through it, and it then repeats the same hold, release and window.

If the card stays silent for the whole window, the block shuts the contacts down by itself. A host deactivation request does the same from any powered state, abandoning whatever was in progress. Shutdown follows a fixed order with a fixed spacing in system clocks. The card clock divider is programmable and produces a 50 % duty clock. Every interval count advances on the divider's rising-edge strobe.

Top module: `sc_reset_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, the outputs are: `vcc_en_o`=0, `sc_clk_o`=0, `sc_rst_o`=0, `io_drv_low_o`=1, `off_done_o`=1, and `act_o`, `atr_seen_o`, `atr_early_o`, `atr_late_o` all 0.
- R2: While running, `sc_clk_o` stays high for exactly H system clocks and low for exactly H system clocks, where H is `div_half` and a value of 0 is treated as 1.
- R3: A cold request accepted in the off state sets `vcc_en_o` and `act_o` in the next cycle. The first `sc_clk_o` rising edge follows STEP_CLKS+H system clocks after that.
- R4: After a cold or warm start, `sc_rst_o` stays low until the RST_HOLD-th card clock rising edge and rises on that same edge.
- R5: `io_drv_low_o` falls (I/O released) on the IO_REL-th card clock rising edge of the reset hold.
- R6: A falling edge on `io_in` while the window is open, with k card clock rises counted since `sc_rst_o` rose and ATR_MIN <= k < ATR_MAX, sets `atr_seen_o` and leaves the contacts powered with `sc_rst_o` high.
- R7: A falling edge seen with k < ATR_MIN sets `atr_early_o`, is not taken as an answer, and the window stays open for a later valid edge.
- R8: If no valid edge arrives, `atr_late_o` sets and `sc_rst_o` drops on the ATR_MAX-th card clock rise after `sc_rst_o` rose, which starts deactivation.
- R9: Deactivation begins with `sc_rst_o` low at cycle 0. `sc_clk_o` is low and still from cycle STEP_CLKS+1 on. `io_drv_low_o` rises at cycle 2*STEP_CLKS. `vcc_en_o` falls, `off_done_o` rises and `act_o` falls at cycle 3*STEP_CLKS.
- R10: A deactivation request in any powered, non-deactivating state drops `sc_rst_o` in the next cycle and runs the R9 sequence, aborting any reset hold or answer wait.
- R11: A warm request is taken only once an answer has been seen. It drops `sc_rst_o` and re-drives I/O low in the next cycle while `vcc_en_o` stays high and the card clock keeps running.
- R12: Requests that do not apply have no effect: cold while powered, warm in the off state, and deactivate in the off state.
- R13: Accepting a cold or warm start clears `atr_seen_o`, `atr_early_o` and `atr_late_o`, and a cold start clears `off_done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_half | input | DIV_W | Card clock half period in system clocks (0 acts as 1) |
| cold_req | input | 1 | Start a cold reset from the off state |
| warm_req | input | 1 | Start a warm reset from an established session |
| deact_req | input | 1 | Abort and deactivate the contacts |
| io_in | input | 1 | Sensed level of the card I/O line |
| vcc_en_o | output | 1 | Card supply enable |
| sc_clk_o | output | 1 | Card clock |
| sc_rst_o | output | 1 | Card reset line (low = reset asserted) |
| io_drv_low_o | output | 1 | 1 drives card I/O low, 0 releases it to the pull-up |
| act_o | output | 1 | Contacts powered and sequence in progress |
| atr_seen_o | output | 1 | Valid answer start edge received |
| atr_early_o | output | 1 | Start edge arrived before the window opened |
| atr_late_o | output | 1 | Window expired without an answer |
| off_done_o | output | 1 | Contacts fully deactivated |

## Verification
The bench builds the block with RST_HOLD=24, IO_REL=5, ATR_MIN=8, ATR_MAX=30, STEP_CLKS=3 and a 4-bit divider field. With these values a complete cold or warm cycle, including the expiry of the full window, takes only a few hundred system clocks, so many sessions fit in one run. Divider settings of 4 to 7 keep the input synchronizer latency shorter than one card clock period, so the index of the arriving edge is exact. A setting of 0 exercises the clamp to a one-cycle half period and an abort during the reset hold.

// File: rtl/sc_seq_pkg.sv
package sc_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_PWR,
    ST_HOLD,
    ST_WAIT,
    ST_SESS,
    ST_DEACT
  } seq_state_e;
endpackage

// File: rtl/sc_clk_div.sv
module sc_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             sc_clk_o,
  output logic             rise_o
);
  logic [DIV_W-1:0] half_eff;
  logic [DIV_W-1:0] cnt_q;
  logic             clk_q;
  logic             at_end;

  assign half_eff = (half_i == '0) ? DIV_W'(1) : half_i;
  assign at_end   = (cnt_q >= half_eff - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (at_end) begin
      cnt_q <= '0;
      clk_q <= ~clk_q;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  assign sc_clk_o = clk_q;
  assign rise_o   = run_i && at_end && !clk_q;

  // R9: a stopped divider parks the card clock low
  a_r9_stop_low: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !clk_q);
  // R2: every rising strobe is followed by a high card clock
  a_r2_rise_high: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> clk_q);
endmodule

// File: rtl/sc_io_edge.sv
module sc_io_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic io_i,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_d;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   tail_q;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign sync_d[i] = io_i;
    end else begin : g_next
      assign sync_d[i] = sync_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      tail_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      tail_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall_o = tail_q && !sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/sc_deact_seq.sv
module sc_deact_seq #(
  parameter int STEP_CLKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic clk_stop_o,
  output logic io_low_o,
  output logic pwr_off_o
);
  localparam int STEP_W = $clog2(STEP_CLKS + 1);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEP_CLKS - 1);

  logic              busy_q;
  logic [1:0]        step_q;
  logic [STEP_W-1:0] dcnt_q;
  logic              last;

  assign last = busy_q && (dcnt_q == STEP_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      step_q <= '0;
      dcnt_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      step_q <= '0;
      dcnt_q <= '0;
    end else if (busy_q) begin
      if (last) begin
        dcnt_q <= '0;
        step_q <= step_q + 2'd1;
        if (step_q == 2'd2) busy_q <= 1'b0;
      end else begin
        dcnt_q <= dcnt_q + STEP_W'(1);
      end
    end
  end

  assign clk_stop_o = last && (step_q == 2'd0);
  assign io_low_o   = last && (step_q == 2'd1);
  assign pwr_off_o  = last && (step_q == 2'd2);

  // R9: the sequence is never restarted while it runs
  a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
    start_i |-> !busy_q);
  // R9: removing power is the final step
  a_r9_power_last: assert property (@(posedge clk) disable iff (rst)
    pwr_off_o |=> !busy_q);
endmodule

// File: rtl/sc_reset_seq.sv
module sc_reset_seq
  import sc_seq_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int RST_HOLD    = 42000,
  parameter int IO_REL      = 150,
  parameter int ATR_MIN     = 380,
  parameter int ATR_MAX     = 42000,
  parameter int STEP_CLKS   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_half,
  input  logic             cold_req,
  input  logic             warm_req,
  input  logic             deact_req,
  input  logic             io_in,
  output logic             vcc_en_o,
  output logic             sc_clk_o,
  output logic             sc_rst_o,
  output logic             io_drv_low_o,
  output logic             act_o,
  output logic             atr_seen_o,
  output logic             atr_early_o,
  output logic             atr_late_o,
  output logic             off_done_o
);
  localparam int CNT_TOP = (RST_HOLD > ATR_MAX) ? RST_HOLD : ATR_MAX;
  localparam int CNT_W   = $clog2(CNT_TOP + 1);
  localparam int STEP_W  = $clog2(STEP_CLKS + 1);
  localparam logic [CNT_W-1:0]  HOLD_LAST = CNT_W'(RST_HOLD - 1);
  localparam logic [CNT_W-1:0]  IO_LAST   = CNT_W'(IO_REL - 1);
  localparam logic [CNT_W-1:0]  WIN_LO    = CNT_W'(ATR_MIN);
  localparam logic [CNT_W-1:0]  WIN_HI    = CNT_W'(ATR_MAX);
  localparam logic [CNT_W-1:0]  WIN_LAST  = CNT_W'(ATR_MAX - 1);
  localparam logic [STEP_W-1:0] PWR_LAST  = STEP_W'(STEP_CLKS - 1);

  seq_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [STEP_W-1:0] pcnt_q;
  logic vcc_q, run_q, rstn_q, io_low_q, act_q;
  logic seen_q, early_q, late_q, done_q;

  logic rise, fall;
  logic clk_stop, io_low_step, pwr_off;
  logic take_deact, take_cold, take_warm;
  logic atr_good, atr_bad, win_late, go_deact;

  sc_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .run_i    (run_q),
    .half_i   (div_half),
    .sc_clk_o (sc_clk_o),
    .rise_o   (rise)
  );

  sc_io_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .io_i   (io_in),
    .fall_o (fall)
  );

  sc_deact_seq #(.STEP_CLKS(STEP_CLKS)) u_deact (
    .clk        (clk),
    .rst        (rst),
    .start_i    (go_deact),
    .clk_stop_o (clk_stop),
    .io_low_o   (io_low_step),
    .pwr_off_o  (pwr_off)
  );

  always_comb begin
    take_deact = deact_req && (state_q != ST_OFF) && (state_q != ST_DEACT);
    take_cold  = cold_req && (state_q == ST_OFF);
    take_warm  = warm_req && !deact_req && (state_q == ST_SESS);
    atr_good   = (state_q == ST_WAIT) && fall && (cnt_q >= WIN_LO);
    atr_bad    = (state_q == ST_WAIT) && fall && (cnt_q < WIN_LO);
    win_late   = (state_q == ST_WAIT) && rise && (cnt_q == WIN_LAST) && !atr_good;
    go_deact   = take_deact || win_late;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_OFF;
      cnt_q    <= '0;
      pcnt_q   <= '0;
      vcc_q    <= 1'b0;
      run_q    <= 1'b0;
      rstn_q   <= 1'b0;
      io_low_q <= 1'b1;
      act_q    <= 1'b0;
      seen_q   <= 1'b0;
      early_q  <= 1'b0;
      late_q   <= 1'b0;
      done_q   <= 1'b1;
    end else if (go_deact) begin
      state_q <= ST_DEACT;
      rstn_q  <= 1'b0;
      if (win_late) late_q <= 1'b1;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          if (take_cold) begin
            state_q <= ST_PWR;
            vcc_q   <= 1'b1;
            act_q   <= 1'b1;
            done_q  <= 1'b0;
            seen_q  <= 1'b0;
            early_q <= 1'b0;
            late_q  <= 1'b0;
            pcnt_q  <= '0;
          end
        end
        ST_PWR: begin
          if (pcnt_q == PWR_LAST) begin
            run_q   <= 1'b1;
            cnt_q   <= '0;
            state_q <= ST_HOLD;
          end else begin
            pcnt_q <= pcnt_q + STEP_W'(1);
          end
        end
        ST_HOLD: begin
          if (rise) begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q == IO_LAST) io_low_q <= 1'b0;
            if (cnt_q == HOLD_LAST) begin
              rstn_q  <= 1'b1;
              cnt_q   <= '0;
              state_q <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (rise) cnt_q <= cnt_q + CNT_W'(1);
          if (atr_bad) early_q <= 1'b1;
          if (atr_good) begin
            seen_q  <= 1'b1;
            state_q <= ST_SESS;
          end
        end
        ST_SESS: begin
          if (take_warm) begin
            rstn_q   <= 1'b0;
            io_low_q <= 1'b1;
            cnt_q    <= '0;
            seen_q   <= 1'b0;
            early_q  <= 1'b0;
            late_q   <= 1'b0;
            state_q  <= ST_HOLD;
          end
        end
        ST_DEACT: begin
          if (clk_stop) run_q <= 1'b0;
          if (io_low_step) io_low_q <= 1'b1;
          if (pwr_off) begin
            vcc_q   <= 1'b0;
            act_q   <= 1'b0;
            done_q  <= 1'b1;
            state_q <= ST_OFF;
          end
        end
        default: state_q <= ST_OFF;
      endcase
    end
  end

  assign vcc_en_o     = vcc_q;
  assign sc_rst_o     = rstn_q;
  assign io_drv_low_o = io_low_q;
  assign act_o        = act_q;
  assign atr_seen_o   = seen_q;
  assign atr_early_o  = early_q;
  assign atr_late_o   = late_q;
  assign off_done_o   = done_q;

  // R4: reset line rises only at the end of a full hold
  a_r4_hold_len: assert property (@(posedge clk) disable iff (rst)
    $rose(rstn_q) |-> ($past(state_q) == ST_HOLD) && ($past(cnt_q) == HOLD_LAST));
  // R6: an accepted answer lies inside the window
  a_r6_in_window: assert property (@(posedge clk) disable iff (rst)
    $rose(seen_q) |-> ($past(cnt_q) >= WIN_LO) && ($past(cnt_q) < WIN_HI));
  // R8: expiry always coincides with entry into shutdown
  a_r8_late_shutdown: assert property (@(posedge clk) disable iff (rst)
    $rose(late_q) |-> (state_q == ST_DEACT) && !rstn_q);
  // R9: supply is removed only after clock stop and I/O low
  a_r9_power_order: assert property (@(posedge clk) disable iff (rst)
    $fell(vcc_q) |-> io_low_q && !run_q && !rstn_q);
  // R5: I/O is released only while the card is powered
  a_r5_release_powered: assert property (@(posedge clk) disable iff (rst)
    !io_low_q |-> vcc_q);
  // R10: a host abort lands in shutdown with reset asserted
  a_r10_abort: assert property (@(posedge clk) disable iff (rst)
    take_deact |=> (state_q == ST_DEACT) && !rstn_q);
endmodule

// File: tb/sc_reset_seq_tb_top.sv
module sc_reset_seq_tb_top;
  localparam int DIV_W = 4, RST_HOLD = 24, IO_REL = 5;
  localparam int ATR_MIN = 8, ATR_MAX = 30, STEP = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic [DIV_W-1:0] div_half = 4'd4;
  logic cold_req = 0, warm_req = 0, deact_req = 0, card_io = 1;
  logic io_line;
  logic vcc_en, sc_clk, sc_rst, io_drv_low, act, atr_seen, atr_early, atr_late, off_done;

  assign io_line = io_drv_low ? 1'b0 : card_io;

  sc_reset_seq #(
    .DIV_W(DIV_W), .RST_HOLD(RST_HOLD), .IO_REL(IO_REL), .ATR_MIN(ATR_MIN),
    .ATR_MAX(ATR_MAX), .STEP_CLKS(STEP), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rst(rst), .div_half(div_half), .cold_req(cold_req),
    .warm_req(warm_req), .deact_req(deact_req), .io_in(io_line),
    .vcc_en_o(vcc_en), .sc_clk_o(sc_clk), .sc_rst_o(sc_rst),
    .io_drv_low_o(io_drv_low), .act_o(act), .atr_seen_o(atr_seen),
    .atr_early_o(atr_early), .atr_late_o(atr_late), .off_done_o(off_done)
  );

  int n_chk = 0, n_bad = 0;
  logic last_clk = 1'b0, rose = 1'b0, fell = 1'b0;

  task automatic tick();
    @(negedge clk);
    rose = sc_clk && !last_clk;
    fell = !sc_clk && last_clk;
    last_clk = sc_clk;
  endtask

  task automatic chk(input string req, input int act_v, input int exp_v);
    n_chk++;
    if (act_v != exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
    end
  endtask

  function automatic int half_eff(input int h);
    return (h == 0) ? 1 : h;
  endfunction

  function automatic int expect_outcome(input int kg, input int ka);
    if (ka > 0 && (kg == 0 || ka < kg)) return 3;
    if (kg >= ATR_MIN && kg < ATR_MAX) return 1;
    return 2;
  endfunction

  task automatic do_cold(input int h);
    int n = 0;
    div_half = DIV_W'(h);
    card_io = 1'b1;
    cold_req = 1'b1; tick(); cold_req = 1'b0;
    chk("R3 vcc on", vcc_en, 1);
    chk("R3 act on", act, 1);
    chk("R13 off_done cleared", off_done, 0);
    chk("R13 flags cleared", {atr_seen, atr_early, atr_late}, 0);
    while (!rose && n < 100) begin tick(); n++; end
    chk("R3 first clock delay", n, STEP + half_eff(h));
  endtask

  task automatic hold_phase(input int h, input int r0);
    int r = r0, rel = -1, hi = 0, lo = 0, run = 0, guard = 0;
    bit seen = (r0 > 0);
    if (seen) run = 1;
    while (!sc_rst && guard < 4000) begin
      tick(); guard++;
      if (rose) begin
        r++;
        if (seen) lo = run;
        run = 1; seen = 1;
      end else if (fell) begin
        hi = run; run = 1;
      end else run++;
      if (rel < 0 && !io_drv_low) rel = r;
    end
    chk("R4 hold rises", r, RST_HOLD);
    chk("R5 release rise", rel, IO_REL);
    chk("R2 high width", hi, half_eff(h));
    chk("R2 low width", lo, half_eff(h));
  endtask

  task automatic atr_phase(input int ke, input int kg, input int ka, output int outcome);
    int r = 0, guard = 0;
    bit rst_drop = 0;
    outcome = 0;
    while (guard < 3000) begin
      tick(); guard++;
      if (rose) r++;
      if (deact_req) begin
        deact_req = 1'b0; outcome = 3;
        chk("R10 abort drops reset", sc_rst, 0);
        break;
      end
      if (atr_seen) begin
        outcome = 1;
        chk("R6 answer index", r, kg);
        chk("R6 contacts stay up", {vcc_en, sc_rst}, 3);
        break;
      end
      if (atr_late) begin
        outcome = 2;
        chk("R8 expiry index", r, ATR_MAX);
        chk("R8 reset dropped", sc_rst, 0);
        break;
      end
      if (!sc_rst) rst_drop = 1;
      if (rose) begin
        if (r == ke) card_io = 1'b0;
        else if (ke > 0 && r == ke + 1) card_io = 1'b1;
        if (r == kg) card_io = 1'b0;
        if (r == ka) deact_req = 1'b1;
      end
    end
    chk("R6 reset held during window", rst_drop, 0);
    if (ke > 0) chk("R7 early flag", atr_early, 1);
    if (ke > 0 && outcome == 1) chk("R7 early not final", atr_seen, 1);
  endtask

  task automatic deact_check(input bit io_rel);
    int io_at = -1, vcc_at = -1;
    bit clk_bad = 0, rst_bad = 0;
    for (int off = 1; off <= 3 * STEP + 2; off++) begin
      tick();
      if (off >= STEP + 1 && (sc_clk || rose)) clk_bad = 1;
      if (sc_rst) rst_bad = 1;
      if (io_at < 0 && io_drv_low) io_at = off;
      if (vcc_at < 0 && !vcc_en) vcc_at = off;
    end
    if (io_rel) chk("R9 io low step", io_at, 2 * STEP);
    chk("R9 supply off step", vcc_at, 3 * STEP);
    chk("R9 clock parked low", clk_bad, 0);
    chk("R9 reset stays low", rst_bad, 0);
    chk("R9 done and idle", {off_done, act}, 2);
    card_io = 1'b1;
  endtask

  task automatic pulse_deact();
    deact_req = 1'b1; tick(); deact_req = 1'b0;
    chk("R10 reset low after request", sc_rst, 0);
  endtask

  int outc;

  initial begin
    void'($urandom(32'h5c1d));
    repeat (4) tick();
    chk("R1 reset outputs", {vcc_en, sc_clk, sc_rst, io_drv_low, act, atr_seen, atr_early, atr_late, off_done}, 9'b000100001);
    rst = 1'b0; tick();
    chk("R1 after release", {vcc_en, sc_clk, sc_rst, io_drv_low, act, atr_seen, atr_early, atr_late, off_done}, 9'b000100001);

    // R12: warm and deactivate while off
    warm_req = 1'b1; tick(); warm_req = 1'b0;
    deact_req = 1'b1; tick(); deact_req = 1'b0;
    repeat (5) tick();
    chk("R12 off ignores requests", {vcc_en, act, off_done, sc_clk}, 4'b0010);

    // directed: good answer at window start, then warm
    do_cold(4); hold_phase(4, 1);
    atr_phase(0, ATR_MIN, 0, outc);
    chk("R6 outcome min edge", outc, 1);
    cold_req = 1'b1; tick(); cold_req = 1'b0;
    repeat (10) tick();
    chk("R12 cold ignored in session", {vcc_en, sc_rst, atr_seen}, 3'b111);
    card_io = 1'b1;
    warm_req = 1'b1; tick(); warm_req = 1'b0;
    chk("R11 warm drops reset only", {vcc_en, sc_rst, io_drv_low}, 3'b101);
    chk("R13 warm clears answer", atr_seen, 0);
    hold_phase(4, 0);
    chk("R11 supply kept", vcc_en, 1);
    atr_phase(0, ATR_MAX - 1, 0, outc);
    chk("R6 outcome last edge", outc, 1);
    pulse_deact(); deact_check(1);

    // directed: early edge then valid edge
    do_cold(5); hold_phase(5, 1);
    atr_phase(ATR_MIN - 1, ATR_MIN + 3, 0, outc);
    chk("R7 outcome after early", outc, 1);
    pulse_deact(); deact_check(1);

    // directed: silent card
    do_cold(4); hold_phase(4, 1);
    atr_phase(0, 0, 0, outc);
    chk("R8 outcome timeout", outc, 2);
    deact_check(1);
    do_cold(4);
    chk("R13 late cleared", atr_late, 0);
    hold_phase(4, 1);
    atr_phase(0, 0, 3, outc);
    chk("R10 abort in window", outc, 3);
    deact_check(1);

    // directed: divider zero clamp, abort inside hold
    begin
      int hi = 0, lo = 0, run = 1, r = 1;
      do_cold(0);
      while (r < 3) begin
        tick();
        if (rose) begin r++; lo = run; run = 1; end
        else if (fell) begin hi = run; run = 1; end
        else run++;
      end
      chk("R2 clamp high", hi, 1);
      chk("R2 clamp low", lo, 1);
      pulse_deact(); deact_check(0);
    end

    // random sessions
    for (int s = 0; s < 20; s++) begin
      int h = 4 + int'($urandom % 4);
      int mode = int'($urandom % 4);
      int ke = 0, kg = 0, ka = 0;
      case (mode)
        0: kg = ATR_MIN + int'($urandom % (ATR_MAX - ATR_MIN));
        1: begin
          ke = 1 + int'($urandom % (ATR_MIN - 1));
          kg = ATR_MIN + 1 + int'($urandom % (ATR_MAX - ATR_MIN - 1));
        end
        2: ke = ($urandom % 2 == 0) ? 0 : 1 + int'($urandom % (ATR_MIN - 1));
        default: ka = 1 + int'($urandom % (ATR_MAX - 2));
      endcase
      do_cold(h); hold_phase(h, 1);
      atr_phase(ke, kg, ka, outc);
      chk("R6 R8 R10 random outcome", outc, expect_outcome(kg, ka));
      if (outc == 1) begin
        if (mode == 0 && ($urandom % 2 == 0)) begin
          card_io = 1'b1;
          warm_req = 1'b1; tick(); warm_req = 1'b0;
          chk("R11 random warm", {vcc_en, sc_rst}, 2'b10);
          hold_phase(h, 0);
          atr_phase(0, kg, 0, outc);
          chk("R11 random warm answer", outc, 1);
        end
        pulse_deact();
      end
      deact_check(1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule